// File: doc/BRIEF.md
# Flash Read Protection Controller

This block keeps the read protection level of an on-chip flash and enforces it. The level comes from an 8-bit protection option byte held in the block. One code value opens the device and a second code value locks it for good. Every other value gives the middle level, which is also the level after the option byte has been erased. Each flash or backup-SRAM access (read, program or erase) is tagged with its target, its sector and its operation. The block grants or denies it according to the level, the boot source, whether a debugger is attached, and a per-sector write-protect mask. A denied read is flagged as a bus error.

Requests to change the option byte arrive on a valid/ready channel. A transfer takes place on a clock edge where `opt_wr_valid` and `opt_wr_ready` are both high. `opt_wr_ready` is low for the whole of a mass erase, and a valid offered while ready is low is dropped, not queued. Moving from the middle level to the open level starts a mass erase through a one-cycle `erase_start` pulse. The new byte is committed only when `erase_done` arrives. Raising the level commits at once. At the locked level every change is refused and a sticky error flag is raised. The locked level also drives a permanent debug-port disable and blocks boot from anything but user flash. The flash array and the erase engine sit outside this block.

The access channel has no back-pressure. Each cycle with `acc_valid` high gives exactly one response, one cycle later.

Top module: `rdprot_ctrl`

## Requirements
- R1: The option byte decodes to a level: 0xAA gives level 0, 0xCC gives level 2, and every other value gives level 1. `prot_level` shows the level as 0, 1 or 2. After reset the byte is 0xFF, so the level is 1.
- R2: At level 0, every access is granted for any boot source and any debugger state, unless R5 denies it.
- R3: At level 1, an access is denied while `dbg_attached` is high or `boot_sel` is not user flash (boot_sel encoding: 0 user flash, 1 system memory, 2 RAM, 3 reserved and handled like RAM). A denied read (acc_op 0) raises `rsp_buserr`. A denied program (acc_op 1) or erase (acc_op 2 or 3) does not.
- R4: At level 1 or 2, booting from user flash with no debugger attached, an access is granted unless R5 denies it.
- R5: A program or erase to flash (acc_target 0) is denied at every level when the sector's bit in `wrprot_mask` is set, with no bus error. Reads, backup-SRAM accesses (acc_target 1) and sector numbers at or above NSECT are not affected by the mask.
- R6: `rsp_valid` is high exactly in the cycle after a cycle with `acc_valid` high. `rsp_grant` and `rsp_buserr` are valid while `rsp_valid` is high.
- R7: A write of 0xAA accepted at level 1 raises `erase_start` for exactly one cycle and `busy` in the following cycle. The level stays 1 until the clock edge that samples `erase_done` high; from then on it is 0 and `busy` is low.
- R8: While `busy` is high, `opt_wr_ready` is low, every access is denied (a read with a bus error), and an option write offered in that time has no effect.
- R9: Any accepted write other than level 1 to level 0 commits in the cycle after acceptance without `erase_start`. This covers raising the level (0 to 1, 1 to 2, 0 to 2) and writes that keep the level.
- R10: At level 2, every option write is refused and the level stays 2. A refused write sets `prot_err`, which stays high until a cycle with `prot_err_clr` high.
- R11: At level 2, `dbg_disable` is high, and `boot_blocked` is high whenever `boot_sel` is not user flash. At levels 0 and 1, both are low.
- R12: `erase_done` has no effect when no erase is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_sel | input | 2 | Boot source: 0 user flash, 1 system memory, 2 RAM, 3 reserved |
| dbg_attached | input | 1 | Debugger connected |
| acc_valid | input | 1 | Access request present |
| acc_op | input | 2 | 0 read, 1 program, 2 or 3 erase |
| acc_target | input | 1 | 0 flash, 1 backup SRAM |
| acc_sector | input | SECT_W | Flash sector of the access |
| wrprot_mask | input | NSECT | Per-sector write protection |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access allowed |
| rsp_buserr | output | 1 | Denied read, bus error |
| opt_wr_valid | input | 1 | Option byte write offered |
| opt_wr_byte | input | 8 | Requested option byte |
| opt_wr_ready | output | 1 | Option channel can take a write |
| erase_start | output | 1 | One-cycle mass-erase start |
| erase_done | input | 1 | Mass erase finished |
| busy | output | 1 | Mass erase in progress |
| prot_err_clr | input | 1 | Clears the protection-error flag |
| prot_err | output | 1 | Sticky refused-change flag |
| prot_level | output | 2 | Current level 0, 1 or 2 |
| dbg_disable | output | 1 | Debug, trace and boundary-scan ports off |
| boot_blocked | output | 1 | Selected boot source not permitted |

## Verification
The bench builds the block with NSECT set to 12 and the default reset byte 0xFF and code values. With a 4-bit sector field, sector numbers 12 to 15 can be driven, so the bench reaches addresses beyond the write-protect mask. The reset byte starts every run at level 1, so the bench reaches level 0 only through a full mass-erase handshake. It returns from level 2 only by a fresh reset.

// File: rtl/rdprot_pkg.sv
package rdprot_pkg;

  typedef enum logic [1:0] {
    LVL_OPEN  = 2'd0,
    LVL_GUARD = 2'd1,
    LVL_LOCK  = 2'd2
  } prot_lvl_e;

  localparam logic [1:0] BOOT_FLASH  = 2'd0;
  localparam logic [1:0] BOOT_SYSMEM = 2'd1;
  localparam logic [1:0] BOOT_SRAM   = 2'd2;

  localparam logic [1:0] OP_READ = 2'd0;
  localparam logic [1:0] OP_PROG = 2'd1;

  localparam logic TGT_FLASH  = 1'b0;
  localparam logic TGT_BKPRAM = 1'b1;

endpackage

// File: rtl/rdprot_lvl_decode.sv
module rdprot_lvl_decode
  import rdprot_pkg::*;
#(
  parameter logic [7:0] OPEN_CODE = 8'hAA,
  parameter logic [7:0] LOCK_CODE = 8'hCC
) (
  input  logic [7:0] opt_byte,
  output prot_lvl_e  level
);

  always_comb begin
    if (opt_byte == OPEN_CODE)
      level = LVL_OPEN;
    else if (opt_byte == LOCK_CODE)
      level = LVL_LOCK;
    else
      level = LVL_GUARD;
  end

endmodule

// File: rtl/rdprot_opt_fsm.sv
module rdprot_opt_fsm
  import rdprot_pkg::*;
#(
  parameter logic [7:0] RESET_OPT = 8'hFF,
  parameter logic [7:0] OPEN_CODE = 8'hAA,
  parameter logic [7:0] LOCK_CODE = 8'hCC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  prot_lvl_e  cur_level,
  input  logic       opt_wr_valid,
  input  logic [7:0] opt_wr_byte,
  output logic       opt_wr_ready,
  input  logic       erase_done,
  input  logic       prot_err_clr,
  output logic [7:0] opt_q,
  output logic       busy,
  output logic       erase_start,
  output logic       prot_err
);

  typedef enum logic {ST_IDLE, ST_ERASE} st_e;

  st_e        st_q;
  logic [7:0] pend_q;
  prot_lvl_e  new_level;
  logic       take;
  logic       downgrade;

  rdprot_lvl_decode #(
    .OPEN_CODE(OPEN_CODE),
    .LOCK_CODE(LOCK_CODE)
  ) u_req_decode (
    .opt_byte(opt_wr_byte),
    .level   (new_level)
  );

  assign opt_wr_ready = (st_q == ST_IDLE);
  assign busy         = (st_q == ST_ERASE);
  assign take         = opt_wr_valid && opt_wr_ready;
  assign downgrade    = (cur_level == LVL_GUARD) && (new_level == LVL_OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      opt_q       <= RESET_OPT;
      pend_q      <= RESET_OPT;
      erase_start <= 1'b0;
      prot_err    <= 1'b0;
    end else begin
      erase_start <= 1'b0;
      if (prot_err_clr)
        prot_err <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (take) begin
            if (cur_level == LVL_LOCK) begin
              prot_err <= 1'b1;
            end else if (downgrade) begin
              pend_q      <= opt_wr_byte;
              st_q        <= ST_ERASE;
              erase_start <= 1'b1;
            end else begin
              opt_q <= opt_wr_byte;
            end
          end
        end
        ST_ERASE: begin
          if (erase_done) begin
            opt_q <= pend_q;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  // R7
  erase_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> busy);

  // R10
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_err) |-> $past(prot_err_clr));

  // R10
  lvl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level == LVL_LOCK) |=> (cur_level == LVL_LOCK));

  // R12
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && erase_done && !opt_wr_valid) |=> $stable(opt_q));

endmodule

// File: rtl/rdprot_access_gate.sv
module rdprot_access_gate
  import rdprot_pkg::*;
#(
  parameter int NSECT  = 12,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  prot_lvl_e         level,
  input  logic              busy,
  input  logic [1:0]        boot_sel,
  input  logic              dbg_attached,
  input  logic              acc_valid,
  input  logic [1:0]        acc_op,
  input  logic              acc_target,
  input  logic [SECT_W-1:0] acc_sector,
  input  logic [NSECT-1:0]  wrprot_mask,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_buserr
);

  localparam int SPAN = 1 << SECT_W;

  logic [SPAN-1:0] mask_ext;
  logic            wp_hit;
  logic            restricted;
  logic            allow;

  for (genvar i = 0; i < SPAN; i++) begin : g_mask
    if (i < NSECT) begin : g_real
      assign mask_ext[i] = wrprot_mask[i];
    end else begin : g_pad
      assign mask_ext[i] = 1'b0;
    end
  end

  always_comb begin
    wp_hit     = (acc_target == TGT_FLASH) && (acc_op != OP_READ) && mask_ext[acc_sector];
    restricted = dbg_attached || (boot_sel != BOOT_FLASH);
    if (level == LVL_OPEN)
      allow = 1'b1;
    else
      allow = !restricted;
    if (busy || wp_hit)
      allow = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_grant  <= 1'b0;
      rsp_buserr <= 1'b0;
    end else begin
      rsp_valid  <= acc_valid;
      rsp_grant  <= acc_valid && allow;
      rsp_buserr <= acc_valid && !allow && (acc_op == OP_READ);
    end
  end

  // R6
  rsp_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_valid));

  // R8
  busy_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(busy)) |-> !rsp_grant);

  // R3
  buserr_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_buserr |-> (rsp_valid && !rsp_grant));

endmodule

// File: rtl/rdprot_ctrl.sv
module rdprot_ctrl
  import rdprot_pkg::*;
#(
  parameter int         NSECT     = 12,
  parameter logic [7:0] RESET_OPT = 8'hFF,
  parameter logic [7:0] OPEN_CODE = 8'hAA,
  parameter logic [7:0] LOCK_CODE = 8'hCC,
  localparam int        SECT_W    = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_sel,
  input  logic              dbg_attached,
  input  logic              acc_valid,
  input  logic [1:0]        acc_op,
  input  logic              acc_target,
  input  logic [SECT_W-1:0] acc_sector,
  input  logic [NSECT-1:0]  wrprot_mask,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_buserr,
  input  logic              opt_wr_valid,
  input  logic [7:0]        opt_wr_byte,
  output logic              opt_wr_ready,
  output logic              erase_start,
  input  logic              erase_done,
  output logic              busy,
  input  logic              prot_err_clr,
  output logic              prot_err,
  output logic [1:0]        prot_level,
  output logic              dbg_disable,
  output logic              boot_blocked
);

  logic [7:0] opt_q;
  prot_lvl_e  level;

  rdprot_lvl_decode #(
    .OPEN_CODE(OPEN_CODE),
    .LOCK_CODE(LOCK_CODE)
  ) u_cur_decode (
    .opt_byte(opt_q),
    .level   (level)
  );

  rdprot_opt_fsm #(
    .RESET_OPT(RESET_OPT),
    .OPEN_CODE(OPEN_CODE),
    .LOCK_CODE(LOCK_CODE)
  ) u_opt_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_level   (level),
    .opt_wr_valid(opt_wr_valid),
    .opt_wr_byte (opt_wr_byte),
    .opt_wr_ready(opt_wr_ready),
    .erase_done  (erase_done),
    .prot_err_clr(prot_err_clr),
    .opt_q       (opt_q),
    .busy        (busy),
    .erase_start (erase_start),
    .prot_err    (prot_err)
  );

  rdprot_access_gate #(
    .NSECT (NSECT),
    .SECT_W(SECT_W)
  ) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .level       (level),
    .busy        (busy),
    .boot_sel    (boot_sel),
    .dbg_attached(dbg_attached),
    .acc_valid   (acc_valid),
    .acc_op      (acc_op),
    .acc_target  (acc_target),
    .acc_sector  (acc_sector),
    .wrprot_mask (wrprot_mask),
    .rsp_valid   (rsp_valid),
    .rsp_grant   (rsp_grant),
    .rsp_buserr  (rsp_buserr)
  );

  assign prot_level   = level;
  assign dbg_disable  = (level == LVL_LOCK);
  assign boot_blocked = (level == LVL_LOCK) && (boot_sel != BOOT_FLASH);

  // R11
  dbg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_disable |=> dbg_disable);

  // R9
  no_erase_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && (prot_level != $past(prot_level))) |-> !$past(erase_start));

endmodule

// File: tb/test_rdprot_ctrl.sv
module test_rdprot_ctrl;

  localparam int NSECT  = 12;
  localparam int SECT_W = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        boot_sel;
  logic              dbg_attached;
  logic              acc_valid;
  logic [1:0]        acc_op;
  logic              acc_target;
  logic [SECT_W-1:0] acc_sector;
  logic [NSECT-1:0]  wrprot_mask;
  logic              rsp_valid, rsp_grant, rsp_buserr;
  logic              opt_wr_valid;
  logic [7:0]        opt_wr_byte;
  logic              opt_wr_ready;
  logic              erase_start, erase_done, busy;
  logic              prot_err_clr, prot_err;
  logic [1:0]        prot_level;
  logic              dbg_disable, boot_blocked;

  int checks = 0;
  int fails  = 0;
  logic [1:0] mlvl;

  always #10 clk = ~clk;

  rdprot_ctrl #(.NSECT(NSECT)) i_rdprot_ctrl (
    .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel), .dbg_attached(dbg_attached),
    .acc_valid(acc_valid), .acc_op(acc_op), .acc_target(acc_target),
    .acc_sector(acc_sector), .wrprot_mask(wrprot_mask),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_buserr(rsp_buserr),
    .opt_wr_valid(opt_wr_valid), .opt_wr_byte(opt_wr_byte), .opt_wr_ready(opt_wr_ready),
    .erase_start(erase_start), .erase_done(erase_done), .busy(busy),
    .prot_err_clr(prot_err_clr), .prot_err(prot_err), .prot_level(prot_level),
    .dbg_disable(dbg_disable), .boot_blocked(boot_blocked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] lvl_of(input logic [7:0] b);
    if (b == 8'hAA) return 2'd0;
    if (b == 8'hCC) return 2'd2;
    return 2'd1;
  endfunction

  function automatic logic exp_allow(input logic [1:0] lvl, input logic bsy,
      input logic [1:0] boot, input logic dbg, input logic [1:0] op,
      input logic tgt, input logic [SECT_W-1:0] sec, input logic [NSECT-1:0] mask);
    logic wp;
    wp = (tgt == 1'b0) && (op != 2'd0) && (int'(sec) < NSECT) && mask[sec];
    if (bsy || wp) return 1'b0;
    if (lvl == 2'd0) return 1'b1;
    return !(dbg || boot != 2'd0);
  endfunction

  task automatic do_access(input string tag, input logic [1:0] boot, input logic dbg,
      input logic [1:0] op, input logic tgt, input logic [SECT_W-1:0] sec,
      input logic [NSECT-1:0] mask, input logic bsy);
    logic g;
    @(negedge clk);
    boot_sel = boot; dbg_attached = dbg; acc_op = op; acc_target = tgt;
    acc_sector = sec; wrprot_mask = mask; acc_valid = 1'b1;
    g = exp_allow(mlvl, bsy, boot, dbg, op, tgt, sec, mask);
    @(negedge clk);
    acc_valid = 1'b0;
    chk({tag, " R6 rsp_valid"}, rsp_valid, 1);
    chk({tag, " grant"}, rsp_grant, g);
    chk({tag, " buserr"}, rsp_buserr, !g && op == 2'd0);
  endtask

  task automatic rand_access(input int n);
    for (int i = 0; i < n; i++) begin
      logic [1:0] b; logic d; logic [1:0] o; logic t;
      logic [SECT_W-1:0] s; logic [NSECT-1:0] m; string tag;
      b = 2'($urandom_range(0, 3));
      d = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 2) == 0) begin b = 2'd0; d = 1'b0; end
      o = 2'($urandom_range(0, 3));
      t = 1'($urandom_range(0, 1));
      s = SECT_W'($urandom_range(0, 15));
      m = NSECT'($urandom);
      if (t == 1'b0 && o != 2'd0 && int'(s) < NSECT && m[s]) tag = "R5";
      else if (mlvl == 2'd0) tag = "R2";
      else if (d || b != 2'd0) tag = "R3";
      else tag = "R4";
      do_access(tag, b, d, o, t, s, m, 1'b0);
    end
  endtask

  task automatic opt_write(input string tag, input logic [7:0] v, input logic exp_erase,
      input logic exp_reject);
    @(negedge clk);
    chk({tag, " ready"}, opt_wr_ready, 1);
    opt_wr_byte = v; opt_wr_valid = 1'b1;
    @(negedge clk);
    opt_wr_valid = 1'b0;
    if (!exp_erase && !exp_reject) mlvl = lvl_of(v);
    chk({tag, " erase_start"}, erase_start, exp_erase);
    chk({tag, " busy"}, busy, exp_erase);
    chk({tag, " level"}, prot_level, mlvl);
    if (exp_reject) chk({tag, " prot_err"}, prot_err, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mlvl = 2'd1;
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20561));
    boot_sel = 0; dbg_attached = 0; acc_valid = 0; acc_op = 0; acc_target = 0;
    acc_sector = 0; wrprot_mask = 0; opt_wr_valid = 0; opt_wr_byte = 0;
    erase_done = 0; prot_err_clr = 0;
    do_reset();

    // R1 reset state
    chk("R1 reset level", prot_level, 1);
    chk("R1 reset busy", busy, 0);
    chk("R6 reset rsp_valid", rsp_valid, 0);
    chk("R10 reset prot_err", prot_err, 0);
    chk("R11 reset dbg_disable", dbg_disable, 0);
    chk("R8 reset ready", opt_wr_ready, 1);

    rand_access(150);
    @(negedge clk);
    chk("R6 idle rsp_valid", rsp_valid, 0);

    // R12 erase_done with no erase running
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    chk("R12 level", prot_level, 1);
    chk("R12 busy", busy, 0);

    // R9 same-level write, then R7 downgrade
    opt_write("R9 1to1", 8'h00, 1'b0, 1'b0);
    opt_write("R7 1to0", 8'hAA, 1'b1, 1'b0);
    // R8 access while busy, erase_start dropped after one cycle
    do_access("R8 busy read", 2'd0, 1'b0, 2'd0, 1'b1, 4'd0, '0, 1'b1);
    chk("R7 pulse one cycle", erase_start, 0);
    chk("R7 level held", prot_level, 1);
    // R8 option write while busy is dropped
    @(negedge clk);
    chk("R8 ready low", opt_wr_ready, 0);
    opt_wr_byte = 8'hCC; opt_wr_valid = 1'b1;
    @(negedge clk);
    opt_wr_valid = 1'b0;
    chk("R8 still busy", busy, 1);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    mlvl = 2'd0;
    chk("R7 level after done", prot_level, 0);
    chk("R7 busy after done", busy, 0);
    chk("R8 dropped write", prot_level, 0);

    rand_access(150);
    do_access("R2 dbg ram", 2'd2, 1'b1, 2'd0, 1'b0, 4'd3, '0, 1'b0);
    do_access("R5 wp prog", 2'd0, 1'b0, 2'd1, 1'b0, 4'd5, 12'h020, 1'b0);
    do_access("R5 out of range", 2'd0, 1'b0, 2'd2, 1'b0, 4'd14, 12'hFFF, 1'b0);

    // R9 raises without erase
    opt_write("R9 0to1", 8'h5A, 1'b0, 1'b0);
    opt_write("R7 1to0 again", 8'hAA, 1'b1, 1'b0);
    @(negedge clk);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    mlvl = 2'd0;
    chk("R7 level 0 again", prot_level, 0);
    opt_write("R9 0to2", 8'hCC, 1'b0, 1'b0);

    // R11 lock outputs
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      boot_sel = 2'(b);
      #1;
      chk("R11 dbg_disable", dbg_disable, 1);
      chk("R11 boot_blocked", boot_blocked, b != 0);
    end
    rand_access(150);

    // R10 lock refusals and sticky error
    opt_write("R10 2to0", 8'hAA, 1'b0, 1'b1);
    opt_write("R10 2to1", 8'h11, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk("R10 sticky", prot_err, 1);
    prot_err_clr = 1'b1;
    @(negedge clk);
    prot_err_clr = 1'b0;
    chk("R10 cleared", prot_err, 0);
    chk("R10 level kept", prot_level, 2);

    // R9 1to2 after fresh reset
    do_reset();
    opt_write("R9 1to2", 8'hCC, 1'b0, 1'b0);
    chk("R11 dbg_disable 1to2", dbg_disable, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule